// File: doc/BRIEF.md
# Debug Breakpoint and Background Control

This block sits beside a small 8-bit CPU and decides when the core must stop running the user program and enter background (halted debug) mode. It holds a debug control/status register that only the serial debug interface can reach. The debug side writes the register through a control-write strobe and sees its value on a status output. No CPU bus path leads to it. The same debug port loads a 16-bit breakpoint match register. The block compares that register against every valid CPU address cycle.

A breakpoint works in one of two ways. In force mode, any valid bus cycle whose address equals the match register arms a request. The core then halts at the next instruction boundary, even if the address was an operand or data access. In tag mode, only an opcode fetch from the matching address counts. That fetch marks its entry in a parallel model of the core's 2-deep instruction queue. The halt happens only when the marked entry leaves the end of the queue at an instruction boundary, so a queue flush such as a taken branch discards the mark and no halt follows. The halt request is one registered output and is the same state as the background-active status bit. A resume strobe from the debug host clears both.

Top module: `dbg_bkpt_ctl`

## Requirements
- R1: A normal reset (rst_n low, rst_to_bkgd low) sets ctl_status to 8'h00 and halt_req to 0.
- R2: A reset with rst_to_bkgd high sets ctl_status to 8'hC8 (bits 7, 6 and 3 set) and halt_req to 1.
- R3: The status layout is bit 7 background enable, bit 6 background active, bit 5 breakpoint enable, bit 4 force select (1 = force, 0 = tag), bit 3 clock select, and bits 2..0 read 0. A ctl_wr pulse loads bits 7, 5, 4 and 3 from ctl_wdata, and the next status shows them. Bit 6 and bits 2..0 of ctl_wdata have no effect.
- R4: In force mode, a valid address match arms a request. The first insn_boundary after the match cycle raises halt_req, and status bit 6 is set one cycle after that boundary. A boundary in the same cycle as the match does not use the request.
- R5: In tag mode, an opcode fetch (cpu_addr_vld and cpu_fetch) from the match address tags its queue entry. halt_req rises one cycle after the insn_boundary that retires that entry.
- R6: queue_flush discards all queue entries and their tags, so a flushed tagged opcode never causes a halt.
- R7: With breakpoint enable 0, no address match raises halt_req in either mode.
- R8: With background enable 0, halt_req never rises. Control writes and status reads still work.
- R9: A cycle with cpu_addr_vld low never matches.
- R10: bkgd_go clears halt_req and status bit 6 on the next clock edge.
- R11: Tags keep queue order. An untagged older entry retires without a halt, and the tagged entry behind it halts at the following boundary.
- R12: comm_clk_sel equals status bit 3. It is 0 (alternate debug clock) after a normal reset, and 1 selects the bus clock.
- R13: The match register is loaded through bkpt_ld, and all 16 address bits take part in the compare. An address that differs in one bit does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_to_bkgd | input | 1 | During reset, selects reset into background mode |
| ctl_wr | input | 1 | Debug control-write strobe |
| ctl_wdata | input | 8 | Control-write data |
| ctl_status | output | 8 | Control/status register value for debug status reads |
| bkpt_ld | input | 1 | Load strobe for the breakpoint match register |
| bkpt_ld_addr | input | 16 | Match address to load |
| bkgd_go | input | 1 | Resume command from the debug host |
| cpu_addr | input | 16 | CPU address bus |
| cpu_addr_vld | input | 1 | CPU bus cycle valid |
| cpu_fetch | input | 1 | Current bus cycle is an opcode fetch into the queue |
| insn_boundary | input | 1 | Oldest queue entry retires (instruction boundary) |
| queue_flush | input | 1 | CPU discards its instruction queue |
| halt_req | output | 1 | Registered request to enter background mode |
| comm_clk_sel | output | 1 | Debug communication clock select |

## Verification
The bench targets timing and gating corners. A match on the same cycle as a boundary must wait for the next boundary. A design that checks the match combinationally would halt one instruction early. A flushed tagged fetch must not halt, and a design that keeps tags across a flush would stop on code that never ran. The bench fetches an untagged opcode and then a tagged one and expects the halt only at the second boundary, which catches queue-order mistakes. Further cases check that one differing address bit, an idle bus cycle, or a cleared enable bit each prevent the halt, and that the write path leaves the read-only active bit unchanged.

// File: rtl/dbg_bkpt_pkg.sv
// Package: shared field positions, register type and status packing for the
// debug breakpoint controller. Assumes an 8-bit status word with three
// reserved low bits that always read zero.
package dbg_bkpt_pkg;

    localparam int STAT_W    = 8;
    localparam int B_BG_EN   = 7;
    localparam int B_ACTIVE  = 6;
    localparam int B_BK_EN   = 5;
    localparam int B_FORCE   = 4;
    localparam int B_CLK_SEL = 3;

    typedef struct packed {
        logic bg_en;
        logic active;
        logic bk_en;
        logic force_sel;
        logic clk_sel;
    } dbg_ctl_t;

    localparam dbg_ctl_t CTL_RST_NORMAL = '{bg_en: 1'b0, active: 1'b0, bk_en: 1'b0,
                                            force_sel: 1'b0, clk_sel: 1'b0};
    localparam dbg_ctl_t CTL_RST_BKGD   = '{bg_en: 1'b1, active: 1'b1, bk_en: 1'b0,
                                            force_sel: 1'b0, clk_sel: 1'b1};

    // Build the externally visible status word from the register fields.
    function automatic logic [STAT_W-1:0] pack_status(input dbg_ctl_t c);
        logic [STAT_W-1:0] s;
        s            = '0;
        s[B_BG_EN]   = c.bg_en;
        s[B_ACTIVE]  = c.active;
        s[B_BK_EN]   = c.bk_en;
        s[B_FORCE]   = c.force_sel;
        s[B_CLK_SEL] = c.clk_sel;
        return s;
    endfunction

endpackage

// File: rtl/dbg_ctl_reg.sv
// Module: debug control/status register. Only the debug port writes it.
// Writable fields are loaded on wr_en. The active bit is set by enter and
// cleared by leave. Assumes enter is only asserted while active is 0.
module dbg_ctl_reg
    import dbg_bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_to_bkgd,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    input  logic              enter,
    input  logic              leave,
    output dbg_ctl_t          ctl
);

    // Register update: reset value choice, debug writes, background entry/exit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= rst_to_bkgd ? CTL_RST_BKGD : CTL_RST_NORMAL;
        end else begin
            if (wr_en) begin
                ctl.bg_en     <= wr_data[B_BG_EN];
                ctl.bk_en     <= wr_data[B_BK_EN];
                ctl.force_sel <= wr_data[B_FORCE];
                ctl.clk_sel   <= wr_data[B_CLK_SEL];
            end
            if (leave) begin
                ctl.active <= 1'b0;
            end else if (enter) begin
                ctl.active <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/dbg_addr_match.sv
// Module: breakpoint match register and full-width address comparator.
// The debug port loads the register. Only valid bus cycles can match.
module dbg_addr_match #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_vld,
    output logic              hit
);

    logic [ADDR_W-1:0] match_q;

    // Hold the match address loaded by the debug host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
        end else if (ld) begin
            match_q <= ld_addr;
        end
    end

    // Compare the qualified bus address with the stored match address.
    always_comb begin
        hit = addr_vld && (addr == match_q);
    end

endmodule

// File: rtl/dbg_tag_queue.sv
// Module: tag shadow of the CPU instruction queue. Each fetch pushes one
// entry with its tag bit. An instruction boundary retires the oldest entry,
// and a flush empties everything. Assumes the CPU never fetches into a full
// queue; such a push is dropped.
module dbg_tag_queue #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic push_tag,
    input  logic pop,
    input  logic flush,
    output logic head_valid,
    output logic head_tag
);

    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] cnt_q, cnt_n;
    logic          tag_q [DEPTH];
    logic          tag_n [DEPTH];

    // Next-state: flush, else shift out on pop, then append the new entry.
    always_comb begin
        cnt_n = cnt_q;
        for (int i = 0; i < DEPTH; i++) begin
            tag_n[i] = tag_q[i];
        end
        if (flush) begin
            cnt_n = '0;
            for (int i = 0; i < DEPTH; i++) begin
                tag_n[i] = 1'b0;
            end
        end else begin
            if (pop && (cnt_q != '0)) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    tag_n[i] = tag_q[i+1];
                end
                tag_n[DEPTH-1] = 1'b0;
                cnt_n          = cnt_q - CW'(1);
            end
            if (push && (cnt_n < CW'(DEPTH))) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (int'(cnt_n) == i) begin
                        tag_n[i] = push_tag;
                    end
                end
                cnt_n = cnt_n + CW'(1);
            end
        end
    end

    // Occupancy counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_n;
        end
    end

    // One tag flop per queue slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g] <= 1'b0;
            end else begin
                tag_q[g] <= tag_n[g];
            end
        end
    end

    // The oldest entry sits in slot 0.
    always_comb begin
        head_valid = (cnt_q != '0);
        head_tag   = tag_q[0];
    end

endmodule

// File: rtl/dbg_bkpt_ctl.sv
// Module: top of the debug breakpoint and background controller. It joins
// the debug register, the address comparator and the tag queue, keeps the
// armed force request, and decides background entry at instruction
// boundaries. Assumes the core stops issuing boundaries while halted.
module dbg_bkpt_ctl
    import dbg_bkpt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int QDEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_to_bkgd,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_status,
    input  logic              bkpt_ld,
    input  logic [ADDR_W-1:0] bkpt_ld_addr,
    input  logic              bkgd_go,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_addr_vld,
    input  logic              cpu_fetch,
    input  logic              insn_boundary,
    input  logic              queue_flush,
    output logic              halt_req,
    output logic              comm_clk_sel
);

    dbg_ctl_t ctl;
    logic     hit;
    logic     head_valid;
    logic     head_tag;
    logic     force_pend_q;
    logic     arm_force;
    logic     push;
    logic     push_tag;
    logic     enter;

    dbg_ctl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_to_bkgd (rst_to_bkgd),
        .wr_en       (ctl_wr),
        .wr_data     (ctl_wdata),
        .enter       (enter),
        .leave       (bkgd_go),
        .ctl         (ctl)
    );

    dbg_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld       (bkpt_ld),
        .ld_addr  (bkpt_ld_addr),
        .addr     (cpu_addr),
        .addr_vld (cpu_addr_vld),
        .hit      (hit)
    );

    dbg_tag_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_tag   (push_tag),
        .pop        (insn_boundary),
        .flush      (queue_flush),
        .head_valid (head_valid),
        .head_tag   (head_tag)
    );

    // Classify a hit as a force request or a fetch tag according to the mode.
    always_comb begin
        push      = cpu_addr_vld && cpu_fetch;
        push_tag  = hit && ctl.bk_en && !ctl.force_sel;
        arm_force = hit && ctl.bk_en && ctl.force_sel;
    end

    // Armed force request: a new hit sets it and the next boundary uses it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_pend_q <= 1'b0;
        end else begin
            force_pend_q <= (force_pend_q && !insn_boundary) || arm_force;
        end
    end

    // Background entry at a boundary when permitted and a breakpoint is due.
    always_comb begin
        enter = insn_boundary && ctl.bg_en && ctl.bk_en && !ctl.active &&
                (force_pend_q || (head_valid && head_tag));
    end

    // Drive the outputs from the register state.
    always_comb begin
        ctl_status   = pack_status(ctl);
        halt_req     = ctl.active;
        comm_clk_sel = ctl.clk_sel;
    end

endmodule

// File: rtl/dbg_bkpt_ctl_chk.sv
// Module: assertion checker for dbg_bkpt_ctl, bound to every instance.
// It observes only top-level ports.
module dbg_bkpt_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst_to_bkgd,
    input logic       ctl_wr,
    input logic [7:0] ctl_status,
    input logic       bkgd_go,
    input logic       insn_boundary,
    input logic       halt_req
);

    // R1: a normal reset clears the whole register.
    p_reset_clear_r1: assert property (@(posedge clk)
        (!rst_n && !rst_to_bkgd) |=> (ctl_status == 8'h00 && !halt_req));

    // R2: a reset into background mode leaves enable, active and clock select set.
    p_reset_bkgd_r2: assert property (@(posedge clk)
        (!rst_n && rst_to_bkgd) |=> (ctl_status == 8'hC8 && halt_req));

    // R3: a control write alone does not move the read-only active bit.
    p_active_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !insn_boundary && !bkgd_go) |=> (ctl_status[6] == $past(ctl_status[6])));

    // R4: a halt only begins right after an instruction boundary.
    p_halt_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(insn_boundary));

    // R8: a halt needs both background enable and breakpoint enable.
    p_halt_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_req) |-> $past(ctl_status[7] && ctl_status[5]));

    // R10: resume clears the halt and the active bit on the next edge.
    p_go_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bkgd_go |=> (!halt_req && !ctl_status[6]));

endmodule

bind dbg_bkpt_ctl dbg_bkpt_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rst_to_bkgd   (rst_to_bkgd),
    .ctl_wr        (ctl_wr),
    .ctl_status    (ctl_status),
    .bkgd_go       (bkgd_go),
    .insn_boundary (insn_boundary),
    .halt_req      (halt_req)
);

// File: tb/dbg_bkpt_ctl_test.sv
module dbg_bkpt_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MATCH = 16'h1234;

    // Control-write vectors: {write data, expected status}.
    localparam int NVEC = 8;
    localparam logic [15:0] VEC [NVEC] = '{
        16'hFF_B8, 16'h40_00, 16'h80_80, 16'h20_20,
        16'h10_10, 16'h08_08, 16'h07_00, 16'hB8_B8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_to_bkgd = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = 8'h00;
    logic [7:0]  ctl_status;
    logic        bkpt_ld = 1'b0;
    logic [15:0] bkpt_ld_addr = 16'h0000;
    logic        bkgd_go = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_addr_vld = 1'b0;
    logic        cpu_fetch = 1'b0;
    logic        insn_boundary = 1'b0;
    logic        queue_flush = 1'b0;
    logic        halt_req;
    logic        comm_clk_sel;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dbg_bkpt_ctl uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .rst_to_bkgd   (rst_to_bkgd),
        .ctl_wr        (ctl_wr),
        .ctl_wdata     (ctl_wdata),
        .ctl_status    (ctl_status),
        .bkpt_ld       (bkpt_ld),
        .bkpt_ld_addr  (bkpt_ld_addr),
        .bkgd_go       (bkgd_go),
        .cpu_addr      (cpu_addr),
        .cpu_addr_vld  (cpu_addr_vld),
        .cpu_fetch     (cpu_fetch),
        .insn_boundary (insn_boundary),
        .queue_flush   (queue_flush),
        .halt_req      (halt_req),
        .comm_clk_sel  (comm_clk_sel)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Let one clock edge pass, then drop all strobes (inputs change at negedge).
    task automatic tick();
        @(negedge clk);
        ctl_wr = 1'b0; bkpt_ld = 1'b0; bkgd_go = 1'b0;
        cpu_addr_vld = 1'b0; cpu_fetch = 1'b0;
        insn_boundary = 1'b0; queue_flush = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d; tick();
    endtask

    task automatic bus(input logic [15:0] a, input logic vld, input logic fetch);
        cpu_addr = a; cpu_addr_vld = vld; cpu_fetch = fetch; tick();
    endtask

    task automatic boundary();
        insn_boundary = 1'b1; tick();
    endtask

    task automatic go();
        bkgd_go = 1'b1; tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 / R12: normal reset state.
        repeat (3) @(negedge clk);
        check("R1 status", {8'h00, ctl_status}, 16'h0000);
        check("R1 halt", {15'h0, halt_req}, 16'h0000);
        check("R12 clk_sel reset", {15'h0, comm_clk_sel}, 16'h0000);
        rst_n = 1'b1;
        tick();

        // R3 / R12: control write vectors.
        for (int i = 0; i < NVEC; i++) begin
            wr_ctl(VEC[i][15:8]);
            check("R3 write readback", {8'h00, ctl_status}, {8'h00, VEC[i][7:0]});
            check("R12 clk_sel follows bit3", {15'h0, comm_clk_sel}, {15'h0, VEC[i][3]});
        end

        bkpt_ld = 1'b1; bkpt_ld_addr = MATCH; tick();

        // R4: force mode, data (non-fetch) match, halt at next boundary.
        wr_ctl(8'hB0);
        bus(MATCH, 1'b1, 1'b0);
        check("R4 no halt before boundary", {15'h0, halt_req}, 16'h0000);
        boundary();
        check("R4 halt after boundary", {15'h0, halt_req}, 16'h0001);
        check("R4 status active", {8'h00, ctl_status}, 16'h00F0);
        go();
        check("R10 go clears halt", {15'h0, halt_req}, 16'h0000);
        check("R10 go clears active", {8'h00, ctl_status}, 16'h00B0);

        // R4: match on the boundary cycle waits for the following boundary.
        cpu_addr = MATCH; cpu_addr_vld = 1'b1; insn_boundary = 1'b1; tick();
        check("R4 same-cycle boundary no halt", {15'h0, halt_req}, 16'h0000);
        boundary();
        check("R4 next boundary halts", {15'h0, halt_req}, 16'h0001);
        go();

        // R13: one differing bit does not match.
        bus(MATCH ^ 16'h8000, 1'b1, 1'b0);
        boundary();
        check("R13 bit15 differs no halt", {15'h0, halt_req}, 16'h0000);
        bus(MATCH ^ 16'h0001, 1'b1, 1'b0);
        boundary();
        check("R13 bit0 differs no halt", {15'h0, halt_req}, 16'h0000);

        // R9: invalid bus cycle never matches.
        bus(MATCH, 1'b0, 1'b0);
        boundary();
        check("R9 idle cycle no halt", {15'h0, halt_req}, 16'h0000);

        // R5: tag mode halts when the tagged opcode retires.
        wr_ctl(8'hA0);
        bus(MATCH, 1'b1, 1'b1);
        check("R5 no halt at fetch", {15'h0, halt_req}, 16'h0000);
        boundary();
        check("R5 tag halts at retire", {15'h0, halt_req}, 16'h0001);
        check("R5 status active", {8'h00, ctl_status}, 16'h00E0);
        go();

        // R6: flushed tag causes no halt.
        bus(MATCH, 1'b1, 1'b1);
        queue_flush = 1'b1; tick();
        bus(16'h2000, 1'b1, 1'b1);
        boundary();
        check("R6 flushed tag no halt", {15'h0, halt_req}, 16'h0000);

        // R11: order kept through the queue.
        bus(16'h1000, 1'b1, 1'b1);
        bus(MATCH, 1'b1, 1'b1);
        boundary();
        check("R11 older untagged entry no halt", {15'h0, halt_req}, 16'h0000);
        boundary();
        check("R11 tagged entry halts", {15'h0, halt_req}, 16'h0001);
        go();

        // R5: a non-fetch match in tag mode sets no tag.
        bus(MATCH, 1'b1, 1'b0);
        bus(16'h3000, 1'b1, 1'b1);
        boundary();
        check("R5 data match in tag mode no halt", {15'h0, halt_req}, 16'h0000);

        // R7: breakpoint disabled, both modes.
        wr_ctl(8'h90);
        bus(MATCH, 1'b1, 1'b0);
        boundary();
        check("R7 force mode disabled", {15'h0, halt_req}, 16'h0000);
        wr_ctl(8'h80);
        bus(MATCH, 1'b1, 1'b1);
        boundary();
        check("R7 tag mode disabled", {15'h0, halt_req}, 16'h0000);

        // R8: background disabled, status path still works.
        wr_ctl(8'h30);
        bus(MATCH, 1'b1, 1'b0);
        boundary();
        check("R8 no halt without enable", {15'h0, halt_req}, 16'h0000);
        check("R8 status still readable", {8'h00, ctl_status}, 16'h0030);

        // R2 / R12: reset into background mode.
        rst_n = 1'b0; rst_to_bkgd = 1'b1;
        tick(); tick();
        check("R2 status after bkgd reset", {8'h00, ctl_status}, 16'h00C8);
        check("R2 halt after bkgd reset", {15'h0, halt_req}, 16'h0001);
        check("R12 clk_sel after bkgd reset", {15'h0, comm_clk_sel}, 16'h0001);
        rst_n = 1'b1; rst_to_bkgd = 1'b0;
        tick();
        go();
        check("R10 go after bkgd reset", {8'h00, ctl_status}, 16'h0088);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule